// File: doc/BRIEF.md
# Reference-Based Frequency Lock Detector

This block tells a clock-recovery loop's supervisor whether the recovered full-rate clock runs at the right frequency. A slow reference clock runs at nominally 1/DIV of the expected oscillator rate. The block divides the recovered clock by DIV and counts the divided ticks over a window of WIN reference cycles. When the count falls more than TOL away from WIN, the clocks differ by more than the ppm limit. With the default DIV=32, WIN=4096 and TOL=4, that limit is about ±1000 ppm.

The window timer lives in the reference domain. The tick counter lives in the recovered-clock domain. A window boundary crosses to the recovered domain as a toggle. The finished count returns as a held word together with a second toggle. Both toggles pass through two-flop synchronizers. A loss-of-lock alarm only changes after two consecutive window verdicts agree, so one disturbed window is filtered out. A two-bit rate select picks one of three oscillator bands or a digital mode. The digital mode uses an external full-rate clock and has no loop running, so in that mode the alarm is held low.

Top module: `freq_lock_monitor`

## Requirements
- R1: `lol` is 1 while `rst_n` is low. After reset it stays 1 until two window verdicts in a row are in tolerance, so a single window result never clears it.
- R2: A window is in tolerance when the number of divided recovered ticks is within WIN-TOL to WIN+TOL inclusive. Two consecutive in-tolerance windows drive `lol` to 0.
- R3: Two consecutive out-of-tolerance windows drive `lol` to 1.
- R4: While `lol` is 0, a single out-of-tolerance window between in-tolerance windows leaves `lol` at 0.
- R5: `rate_sel` = 2'b11 (digital mode) drives `lol` to 0 within three reference cycles. `lol` stays 0 for as long as that code is held, even with the recovered clock stopped or off frequency.
- R6: Leaving digital mode sets `lol` to 1 within three reference cycles. It then clears only as in R2.
- R7: A frequency offset whose count deviation stays inside TOL keeps `lol` at 0.
- R8: `rate_sel` codes 2'b00, 2'b01 and 2'b10 select oscillator bands and all keep the detector active. Lock is held on a correct clock and lost on an off-frequency clock under each of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock, nominally recovered rate / DIV |
| rec_clk | input | 1 | Recovered full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| rate_sel | input | 2 | Band select; 2'b11 selects digital mode |
| lol | output | 1 | Loss-of-lock alarm, active high, reference domain |

## Verification
The recovered clock is driven in several ways:
- at the exact rate, where the count sits at WIN;
- with a small period offset that stays inside tolerance, which separates a correct threshold from one that is too tight;
- with a larger offset that must raise the alarm.

A short stop of the recovered clock, placed in the middle of one window, tells real two-window hysteresis apart from a single-window decision. Stopping the clock during digital mode, and then resuming in each band code, shows that the mode gating and the band decode act independently of the measurement.

// File: rtl/flm_pkg.sv
package flm_pkg;

    typedef enum logic [1:0] {
        BAND_LOW  = 2'b00,
        BAND_MID  = 2'b01,
        BAND_HIGH = 2'b10,
        BAND_EXT  = 2'b11
    } rate_mode_e;

    // Digital mode: external full-rate clock, no recovery loop
    function automatic logic is_ext_mode(logic [1:0] sel);
        return rate_mode_e'(sel) == BAND_EXT;
    endfunction

endpackage

// File: rtl/flm_sync2.sv
module flm_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {2{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[1];
endmodule

// File: rtl/flm_rec_counter.sv
module flm_rec_counter #(
    parameter int DIV = 32,
    parameter int CW  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_tgl_s,
    output logic          res_tgl,
    output logic [CW-1:0] held
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] div;
        logic [CW-1:0] cnt;
        logic [CW-1:0] held;
        logic          seen;
        logic          res_tgl;
    } rec_st_t;

    rec_st_t s_d, s_q;
    logic          tick;
    logic          bnd;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        s_d     = s_q;
        tick    = (s_q.div == DW'(DIV - 1));
        s_d.div = tick ? '0 : s_q.div + 1'b1;
        cnt_inc = (tick && (s_q.cnt != '1)) ? s_q.cnt + 1'b1 : s_q.cnt;
        bnd     = win_tgl_s ^ s_q.seen;
        s_d.seen = win_tgl_s;
        if (bnd) begin
            s_d.held    = cnt_inc;
            s_d.cnt     = '0;
            s_d.res_tgl = ~s_q.res_tgl;
        end else begin
            s_d.cnt     = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_tgl = s_q.res_tgl;
    assign held    = s_q.held;

    // R2: the result word only moves together with its toggle
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(s_q.res_tgl) |-> $stable(held));
endmodule

// File: rtl/flm_ref_window.sv
module flm_ref_window
    import flm_pkg::*;
#(
    parameter int WIN = 4096,
    parameter int TOL = 4,
    parameter int CW  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_tgl_s,
    input  logic [CW-1:0] held,
    input  logic [1:0]    sel_s,
    output logic          win_tgl,
    output logic          alarm
);
    localparam int            WW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LO = CW'(WIN - TOL);
    localparam logic [CW-1:0] HI = CW'(WIN + TOL);

    typedef struct packed {
        logic [WW-1:0] win;
        logic          win_tgl;
        logic          seen;
        logic          pv;
        logic          pok;
        logic          unlock;
        logic          alarm;
    } ref_st_t;

    localparam ref_st_t RST_ST = '{win: '0, win_tgl: 1'b0, seen: 1'b0,
                                   pv: 1'b0, pok: 1'b0, unlock: 1'b1, alarm: 1'b1};

    ref_st_t s_d, s_q;
    logic    evt;
    logic    byp;
    logic    in_tol;

    always_comb begin
        s_d      = s_q;
        evt      = res_tgl_s ^ s_q.seen;
        s_d.seen = res_tgl_s;
        byp      = is_ext_mode(sel_s);
        in_tol   = (held >= LO) && (held <= HI);

        if (s_q.win == WW'(WIN - 1)) begin
            s_d.win     = '0;
            s_d.win_tgl = ~s_q.win_tgl;
        end else begin
            s_d.win     = s_q.win + 1'b1;
        end

        if (byp) begin
            s_d.pv     = 1'b0;
            s_d.unlock = 1'b1;
        end else if (evt) begin
            if (s_q.pv && (s_q.pok == in_tol))
                s_d.unlock = !in_tol;
            s_d.pv  = 1'b1;
            s_d.pok = in_tol;
        end

        s_d.alarm = !byp && s_d.unlock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_ST;
        else        s_q <= s_d;
    end

    assign win_tgl = s_q.win_tgl;
    assign alarm   = s_q.alarm;

    // R5
    ext_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp |=> !alarm);

    // R4
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && $stable(byp)) |=> $stable(alarm));

    // R3
    lose_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !byp && s_q.pv && !s_q.pok && !in_tol) |=> alarm);

    // R2
    gain_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !byp && s_q.pv && s_q.pok && in_tol) |=> !alarm);
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
    parameter int DIV = 32,
    parameter int WIN = 4096,
    parameter int TOL = 4
) (
    input  logic       ref_clk,
    input  logic       rec_clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       lol
);
    localparam int CW = $clog2(2 * WIN + 2);

    logic          ref_rst_n, rec_rst_n;
    logic          win_tgl, win_tgl_s;
    logic          res_tgl, res_tgl_s;
    logic [CW-1:0] held;
    logic [1:0]    sel_s;

    flm_sync2 #(.RST_VAL(1'b0)) i_ref_rst (
        .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n));
    flm_sync2 #(.RST_VAL(1'b0)) i_rec_rst (
        .clk(rec_clk), .rst_n(rst_n), .d(1'b1), .q(rec_rst_n));

    flm_sync2 #(.RST_VAL(1'b0)) i_win_sync (
        .clk(rec_clk), .rst_n(rec_rst_n), .d(win_tgl), .q(win_tgl_s));
    flm_sync2 #(.RST_VAL(1'b0)) i_res_sync (
        .clk(ref_clk), .rst_n(ref_rst_n), .d(res_tgl), .q(res_tgl_s));

    for (genvar g = 0; g < 2; g++) begin : g_sel_sync
        flm_sync2 #(.RST_VAL(1'b0)) i_sel (
            .clk(ref_clk), .rst_n(ref_rst_n), .d(rate_sel[g]), .q(sel_s[g]));
    end

    flm_rec_counter #(.DIV(DIV), .CW(CW)) i_rec (
        .clk(rec_clk), .rst_n(rec_rst_n), .win_tgl_s(win_tgl_s),
        .res_tgl(res_tgl), .held(held));

    flm_ref_window #(.WIN(WIN), .TOL(TOL), .CW(CW)) i_ref (
        .clk(ref_clk), .rst_n(ref_rst_n), .res_tgl_s(res_tgl_s),
        .held(held), .sel_s(sel_s), .win_tgl(win_tgl), .alarm(lol));
endmodule

// File: tb/test_freq_lock_monitor.sv
`timescale 1ns/1ps
module test_freq_lock_monitor;
    localparam int DIV = 4;
    localparam int WIN = 64;
    localparam int TOL = 2;

    logic       ref_clk = 1'b0;
    logic       rec_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       lol;

    real rec_half = 2.5;
    bit  rec_run  = 1'b1;
    int  checks   = 0;
    int  failures = 0;
    int  refcyc   = 0;
    bit  done     = 1'b0;

    typedef struct {
        bit    exp;
        string req;
    } item_t;
    item_t sb[$];

    always #10 ref_clk = ~ref_clk;
    always begin
        #(rec_half);
        if (rec_run) rec_clk = ~rec_clk;
    end
    always @(posedge ref_clk) refcyc <= rst_n ? refcyc + 1 : 0;

    freq_lock_monitor #(.DIV(DIV), .WIN(WIN), .TOL(TOL)) i_freq_lock_monitor (
        .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n),
        .rate_sel(rate_sel), .lol(lol));

    // monitor: pops each expectation and compares at the next falling edge
    initial forever begin
        wait (sb.size() > 0);
        @(negedge ref_clk);
        begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (lol !== it.exp) begin
                failures++;
                $display("FAIL %s: lol=%0b expected=%0b", it.req, lol, it.exp);
            end
        end
    end

    task automatic expect_lol(bit v, string r);
        item_t it;
        it.exp = v;
        it.req = r;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wait_ref(int n);
        repeat (n) @(posedge ref_clk);
    endtask

    task automatic wait_phase(int p);
        do @(posedge ref_clk); while ((refcyc % WIN) != p);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_ref(3);
        expect_lol(1'b1, "R1 during reset");
        @(negedge ref_clk) rst_n = 1'b1;
        wait_ref(4);
        expect_lol(1'b1, "R1 just after reset");
        wait_ref(WIN + 10);
        expect_lol(1'b1, "R1 one window only");
        wait_ref(5 * WIN);
        expect_lol(1'b0, "R2 exact rate locks");

        rec_half = 2.525;
        wait_ref(4 * WIN);
        expect_lol(1'b0, "R7 small offset inside tolerance");

        rec_half = 2.5;
        wait_ref(2 * WIN);
        wait_phase(24);
        rec_run = 1'b0;
        wait_ref(10);
        rec_run = 1'b1;
        wait_ref(WIN);
        expect_lol(1'b0, "R4 single bad window filtered");
        wait_ref(2 * WIN);
        expect_lol(1'b0, "R4 lock kept after glitch");

        rec_half = 2.65;
        wait_ref(4 * WIN);
        expect_lol(1'b1, "R3 large offset loses lock");

        rate_sel = 2'b11;
        wait_ref(4);
        expect_lol(1'b0, "R5 digital mode quiets alarm");
        rec_run = 1'b0;
        wait_ref(3 * WIN);
        expect_lol(1'b0, "R5 quiet with clock stopped");

        rec_run  = 1'b1;
        rec_half = 2.5;
        rate_sel = 2'b00;
        wait_ref(4);
        expect_lol(1'b1, "R6 exit re-arms alarm");
        wait_ref(5 * WIN);
        expect_lol(1'b0, "R6 relock after exit");

        rate_sel = 2'b01;
        wait_ref(3 * WIN);
        expect_lol(1'b0, "R8 band 01 holds lock");
        rate_sel = 2'b10;
        wait_ref(3 * WIN);
        expect_lol(1'b0, "R8 band 10 holds lock");
        rec_half = 2.65;
        wait_ref(4 * WIN);
        expect_lol(1'b1, "R8 band 10 detects offset");

        rec_half = 2.5;
        rate_sel = 2'b00;
        wait_ref(5 * WIN);
        expect_lol(1'b0, "R2 relock band 00");
        @(negedge ref_clk) rst_n = 1'b0;
        wait_ref(1);
        expect_lol(1'b1, "R1 reset re-asserts");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule